// File: doc/BRIEF.md
# Plug-and-Play Card Configuration Sequencer

This block is the card-side control logic of a plug-and-play expansion card on an 8-bit I/O bus. The host writes a register index to a fixed index port (0x279) and then writes data to a fixed data port (0xA79). The block holds the card's protocol state, its card select number (CSN) and the programmable address of the port the host reads back from. It also carries out the self-clearing global control commands. The unlock key is reduced to a one-cycle `key_ok` input. The serial isolation arbitration appears only as a one-cycle request pulse, raised for each isolation read, that a separate identifier shifter would consume.

Reads are recognised at the programmed read port, whose address is `{hi_byte, 2'b11}`. A CSN read in Config returns the CSN one cycle later with a valid strobe. A wake command that succeeds emits a one-cycle strobe that clears the resource-data pointer. A control command with bit 0 set emits a one-cycle strobe that resets the logical devices.

Top module: `pnp_cfg_seq`

## Requirements
- R1: After reset the state is Wait-for-Key (code 0), the CSN is 0 and the read port is 0x003. The strobes `ldev_rst`, `res_ptr_clr`, `iso_bit_req` and `rd_valid` are low.
- R2: A `key_ok` pulse in Wait-for-Key moves the state to Sleep (code 1) on the next cycle. In any other state `key_ok` has no effect. In Wait-for-Key every data-port write is ignored, and control takes priority over `key_ok` in states other than Wait-for-Key.
- R3: A data write to index 0x00 in Config (code 3) sets the read port to `{data, 2'b11}`. The same write in any other state, and any read of index 0x00, leaves the read port unchanged and returns no valid read.
- R4: A write to control index 0x02 with bit 2 set clears the CSN to 0 in Sleep, Isolation or Config.
- R5: A control write with bit 1 set returns the card to Wait-for-Key and keeps the CSN.
- R6: A control write with bit 0 set raises `ldev_rst` for exactly one cycle and keeps the state and the CSN. Bits 0, 1 and 2 written together take effect in the same cycle. Control writes in Wait-for-Key do nothing.
- R7: In Sleep, a write to index 0x03 whose data equals the CSN moves the card to Isolation (code 2) when the data is zero, or to Config when it is nonzero, and raises `res_ptr_clr` for one cycle. A write with data that does not match, and any wake write outside Sleep, has no effect.
- R8: A write to index 0x06 in Isolation or Config loads the CSN and leaves the card in Config. A read of index 0x06 in Config returns the CSN on `rd_data` with `rd_valid` high one cycle after the read.
- R9: A read of index 0x01 in Isolation raises `iso_bit_req` for one cycle. The same read in any other state does not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_ok | input | 1 | One-cycle pulse: the unlock key was recognised |
| io_wr | input | 1 | I/O write strobe, one cycle |
| io_rd | input | 1 | I/O read strobe, one cycle |
| io_addr | input | ADDR_W | I/O address |
| io_wdata | input | 8 | I/O write data |
| rd_data | output | 8 | Read-back data, valid with rd_valid |
| rd_valid | output | 1 | Read-back data valid, one cycle |
| card_state | output | 2 | 0 Wait-for-Key, 1 Sleep, 2 Isolation, 3 Config |
| csn | output | 8 | Card select number |
| rd_port | output | 10 | Programmed read-port address |
| ldev_rst | output | 1 | Logical-device reset strobe |
| res_ptr_clr | output | 1 | Resource-data pointer clear strobe |
| iso_bit_req | output | 1 | Isolation bit-compare request |

## Verification
The unlock pulse and a control write can arrive on the same clock edge. The bench drives `key_ok` together with a control write of bit 1, once in Sleep and once in Wait-for-Key. In Sleep the card must end up in Wait-for-Key; in Wait-for-Key it must end up in Sleep, with the control write ignored. A single control write carrying all three bits is also judged in the cycle after it: the CSN must be cleared, the card back in Wait-for-Key and `ldev_rst` high.

// File: rtl/pnp_cfg_pkg.sv
package pnp_cfg_pkg;

    localparam int BYTE_W = 8;
    localparam int PORT_W = 10;

    typedef enum logic [1:0] {
        ST_WAIT_KEY = 2'd0,
        ST_SLEEP    = 2'd1,
        ST_ISOLATE  = 2'd2,
        ST_CONFIG   = 2'd3
    } card_state_e;

    localparam logic [BYTE_W-1:0] IDX_RDPORT = 8'h00;
    localparam logic [BYTE_W-1:0] IDX_ISOBIT = 8'h01;
    localparam logic [BYTE_W-1:0] IDX_GCTRL  = 8'h02;
    localparam logic [BYTE_W-1:0] IDX_WAKE   = 8'h03;
    localparam logic [BYTE_W-1:0] IDX_CSN    = 8'h06;

    localparam int GC_LDEV_RST = 0;
    localparam int GC_TO_WAIT  = 1;
    localparam int GC_CSN_CLR  = 2;

    localparam logic [BYTE_W-1:0] RDPORT_HI_RST = 8'h00;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [BYTE_W-1:0] idx;
        logic [BYTE_W-1:0] data;
    } reg_access_t;

    function automatic logic [PORT_W-1:0] rdport_of(input logic [BYTE_W-1:0] hi);
        return {hi, 2'b11};
    endfunction

    function automatic logic awake(input card_state_e s);
        return s != ST_WAIT_KEY;
    endfunction

endpackage

// File: rtl/pnp_bus_decode.sv
module pnp_bus_decode
    import pnp_cfg_pkg::*;
#(
    parameter int                ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] INDEX_PORT = 12'h279,
    parameter logic [ADDR_W-1:0] DATA_PORT  = 12'hA79
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [BYTE_W-1:0] io_wdata,
    input  logic [PORT_W-1:0] rd_port,
    output reg_access_t       acc
);
    localparam int PAD_W = ADDR_W - PORT_W;

    logic [BYTE_W-1:0] idx_q;
    logic              idx_hit;
    logic              dat_hit;
    logic              rdp_hit;

    assign idx_hit = io_wr && (io_addr == INDEX_PORT);
    assign dat_hit = io_wr && (io_addr == DATA_PORT);
    assign rdp_hit = io_rd && (io_addr == {{PAD_W{1'b0}}, rd_port});

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (idx_hit) begin
            idx_q <= io_wdata;
        end
    end

    always_comb begin
        acc.wr   = dat_hit;
        acc.rd   = rdp_hit;
        acc.idx  = idx_q;
        acc.data = io_wdata;
    end
endmodule

// File: rtl/pnp_card_fsm.sv
module pnp_card_fsm
    import pnp_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              key_ok,
    input  reg_access_t       acc,
    output card_state_e       state,
    output logic [BYTE_W-1:0] csn,
    output logic              ptr_clr
);
    card_state_e       state_q, state_d;
    logic [BYTE_W-1:0] csn_q, csn_d;
    logic              wake_ok;
    logic              is_ctrl, is_wake, is_csn;

    assign is_ctrl = acc.wr && (acc.idx == IDX_GCTRL) && awake(state_q);
    assign is_wake = acc.wr && (acc.idx == IDX_WAKE) && (state_q == ST_SLEEP)
                     && (acc.data == csn_q);
    assign is_csn  = acc.wr && (acc.idx == IDX_CSN)
                     && ((state_q == ST_ISOLATE) || (state_q == ST_CONFIG));

    always_comb begin
        state_d = state_q;
        csn_d   = csn_q;
        wake_ok = 1'b0;
        if ((state_q == ST_WAIT_KEY) && key_ok) begin
            state_d = ST_SLEEP;
        end
        if (is_wake) begin
            wake_ok = 1'b1;
            state_d = (acc.data == '0) ? ST_ISOLATE : ST_CONFIG;
        end
        if (is_csn) begin
            csn_d   = acc.data;
            state_d = ST_CONFIG;
        end
        if (is_ctrl) begin
            if (acc.data[GC_CSN_CLR]) csn_d   = '0;
            if (acc.data[GC_TO_WAIT]) state_d = ST_WAIT_KEY;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_WAIT_KEY;
            csn_q   <= '0;
            ptr_clr <= 1'b0;
        end else begin
            state_q <= state_d;
            csn_q   <= csn_d;
            ptr_clr <= wake_ok;
        end
    end

    assign state = state_q;
    assign csn   = csn_q;
endmodule

// File: rtl/pnp_cfg_regs.sv
module pnp_cfg_regs
    import pnp_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  reg_access_t       acc,
    input  card_state_e       state,
    input  logic [BYTE_W-1:0] csn,
    output logic [PORT_W-1:0] rd_port,
    output logic              ldev_rst,
    output logic              iso_req,
    output logic              rd_valid,
    output logic [BYTE_W-1:0] rd_data
);
    logic [BYTE_W-1:0] rdhi_q;
    logic              set_port, do_ldrst, do_iso, do_csnrd;

    assign set_port = acc.wr && (acc.idx == IDX_RDPORT) && (state == ST_CONFIG);
    assign do_ldrst = acc.wr && (acc.idx == IDX_GCTRL) && awake(state)
                      && acc.data[GC_LDEV_RST];
    assign do_iso   = acc.rd && (acc.idx == IDX_ISOBIT) && (state == ST_ISOLATE);
    assign do_csnrd = acc.rd && (acc.idx == IDX_CSN) && (state == ST_CONFIG);

    always_ff @(posedge clk) begin
        if (rst) begin
            rdhi_q   <= RDPORT_HI_RST;
            ldev_rst <= 1'b0;
            iso_req  <= 1'b0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            if (set_port) rdhi_q <= acc.data;
            ldev_rst <= do_ldrst;
            iso_req  <= do_iso;
            rd_valid <= do_csnrd;
            rd_data  <= do_csnrd ? csn : '0;
        end
    end

    assign rd_port = rdport_of(rdhi_q);
endmodule

// File: rtl/pnp_cfg_seq.sv
module pnp_cfg_seq
    import pnp_cfg_pkg::*;
#(
    parameter int                ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] INDEX_PORT = 12'h279,
    parameter logic [ADDR_W-1:0] DATA_PORT  = 12'hA79
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              key_ok,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    output logic [1:0]        card_state,
    output logic [7:0]        csn,
    output logic [9:0]        rd_port,
    output logic              ldev_rst,
    output logic              res_ptr_clr,
    output logic              iso_bit_req
);
    reg_access_t acc;
    card_state_e st;

    pnp_bus_decode #(
        .ADDR_W(ADDR_W), .INDEX_PORT(INDEX_PORT), .DATA_PORT(DATA_PORT)
    ) u_dec (
        .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd),
        .io_addr(io_addr), .io_wdata(io_wdata), .rd_port(rd_port), .acc(acc)
    );

    pnp_card_fsm u_fsm (
        .clk(clk), .rst(rst), .key_ok(key_ok), .acc(acc),
        .state(st), .csn(csn), .ptr_clr(res_ptr_clr)
    );

    pnp_cfg_regs u_regs (
        .clk(clk), .rst(rst), .acc(acc), .state(st), .csn(csn),
        .rd_port(rd_port), .ldev_rst(ldev_rst), .iso_req(iso_bit_req),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    assign card_state = st;
endmodule

// File: rtl/pnp_cfg_seq_chk.sv
module pnp_cfg_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       key_ok,
    input logic       rd_valid,
    input logic [1:0] card_state,
    input logic [7:0] csn,
    input logic [9:0] rd_port,
    input logic       ldev_rst,
    input logic       res_ptr_clr,
    input logic       iso_bit_req
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (card_state == 2'd0 && csn == 8'd0 && rd_port == 10'h003));

    assert_wait_exit_R2: assert property (@(posedge clk) disable iff (rst)
        (card_state == 2'd0) |=> (card_state == 2'd0 || card_state == 2'd1));

    assert_key_moves_R2: assert property (@(posedge clk) disable iff (rst)
        (card_state == 2'd0 && key_ok) |=> (card_state == 2'd1));

    assert_rdport_low_bits_R3: assert property (@(posedge clk) disable iff (rst)
        rd_port[1:0] == 2'b11);

    assert_ldrst_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        ldev_rst |=> !ldev_rst);

    assert_wake_from_sleep_R7: assert property (@(posedge clk) disable iff (rst)
        res_ptr_clr |-> ($past(card_state) == 2'd1
                         && (card_state == 2'd2 || card_state == 2'd3)));

    assert_csn_read_config_R8: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> ($past(card_state) == 2'd3));

    assert_iso_only_R9: assert property (@(posedge clk) disable iff (rst)
        iso_bit_req |-> ($past(card_state) == 2'd2));
endmodule

bind pnp_cfg_seq pnp_cfg_seq_chk u_chk (
    .clk(clk), .rst(rst), .key_ok(key_ok), .rd_valid(rd_valid),
    .card_state(card_state), .csn(csn), .rd_port(rd_port),
    .ldev_rst(ldev_rst), .res_ptr_clr(res_ptr_clr), .iso_bit_req(iso_bit_req)
);

// File: tb/pnp_cfg_seq_tb.sv
`timescale 1ns/1ps
module pnp_cfg_seq_tb;
    localparam logic [11:0] P_IDX = 12'h279;
    localparam logic [11:0] P_DAT = 12'hA79;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        key_ok = 1'b0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [11:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic [1:0]  card_state;
    logic [7:0]  csn;
    logic [9:0]  rd_port;
    logic        ldev_rst, res_ptr_clr, iso_bit_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    logic [9:0] exp_port = 10'h003;

    always #4 clk = ~clk;

    pnp_cfg_seq u_dut (
        .clk(clk), .rst(rst), .key_ok(key_ok), .io_wr(io_wr), .io_rd(io_rd),
        .io_addr(io_addr), .io_wdata(io_wdata), .rd_data(rd_data),
        .rd_valid(rd_valid), .card_state(card_state), .csn(csn),
        .rd_port(rd_port), .ldev_rst(ldev_rst), .res_ptr_clr(res_ptr_clr),
        .iso_bit_req(iso_bit_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk); io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk); io_wr = 1'b0;
    endtask

    task automatic reg_wr(input logic [7:0] idx, input logic [7:0] d);
        bus_wr(P_IDX, idx);
        bus_wr(P_DAT, d);
    endtask

    task automatic reg_rd(input logic [7:0] idx);
        bus_wr(P_IDX, idx);
        @(negedge clk); io_rd = 1'b1; io_addr = {2'b00, exp_port};
        @(negedge clk); io_rd = 1'b0;
    endtask

    task automatic pulse_key();
        @(negedge clk); key_ok = 1'b1;
        @(negedge clk); key_ok = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 state", card_state, 0);
        chk("R1 csn", csn, 0);
        chk("R1 rd_port", rd_port, 10'h003);
        chk("R1 strobes", {ldev_rst, res_ptr_clr, iso_bit_req, rd_valid}, 0);
    endtask

    task automatic t_wait_ignores();
        reg_wr(8'h03, 8'h00);
        chk("R2 wake ignored in wait", card_state, 0);
        reg_wr(8'h02, 8'h01);
        chk("R6 ctrl ignored in wait", ldev_rst, 0);
        pulse_key();
        chk("R2 key to sleep", card_state, 1);
        pulse_key();
        chk("R2 key ignored in sleep", card_state, 1);
        reg_wr(8'h00, 8'h40);
        chk("R3 rdport ignored outside config", rd_port, exp_port);
    endtask

    task automatic t_isolation();
        reg_wr(8'h03, 8'h00);
        chk("R7 wake zero to isolation", card_state, 2);
        chk("R7 ptr clear", res_ptr_clr, 1);
        reg_rd(8'h01);
        chk("R9 iso request", iso_bit_req, 1);
        @(negedge clk);
        chk("R9 iso one cycle", iso_bit_req, 0);
        reg_rd(8'h06);
        chk("R8 no csn read in isolation", rd_valid, 0);
    endtask

    task automatic t_csn_and_port();
        reg_wr(8'h06, 8'h05);
        chk("R8 csn write", csn, 8'h05);
        chk("R8 to config", card_state, 3);
        reg_rd(8'h06);
        chk("R8 read valid", rd_valid, 1);
        chk("R8 read data", rd_data, 8'h05);
        reg_rd(8'h01);
        chk("R9 no iso in config", iso_bit_req, 0);
        reg_wr(8'h00, 8'h40);
        exp_port = 10'h103;
        chk("R3 rdport set", rd_port, exp_port);
        reg_rd(8'h00);
        chk("R3 read ignored port", rd_port, exp_port);
        chk("R3 read ignored valid", rd_valid, 0);
        reg_rd(8'h06);
        chk("R3 new port answers", rd_data, 8'h05);
    endtask

    task automatic t_ctrl_and_wake();
        reg_wr(8'h02, 8'h02);
        chk("R5 to wait", card_state, 0);
        chk("R5 csn kept", csn, 8'h05);
        pulse_key();
        reg_wr(8'h03, 8'h03);
        chk("R7 mismatch ignored", card_state, 1);
        chk("R7 mismatch no clear", res_ptr_clr, 0);
        reg_wr(8'h03, 8'h05);
        chk("R7 wake nonzero to config", card_state, 3);
        chk("R7 ptr clear config", res_ptr_clr, 1);
        reg_wr(8'h02, 8'h01);
        chk("R6 ldev reset", ldev_rst, 1);
        chk("R6 state kept", card_state, 3);
        chk("R6 csn kept", csn, 8'h05);
        @(negedge clk);
        chk("R6 one cycle", ldev_rst, 0);
        reg_wr(8'h02, 8'h04);
        chk("R4 csn cleared", csn, 0);
        chk("R4 state kept", card_state, 3);
    endtask

    task automatic t_same_cycle();
        reg_wr(8'h06, 8'h09);
        reg_wr(8'h02, 8'h07);
        chk("R6 combined ldev", ldev_rst, 1);
        chk("R4 combined csn", csn, 0);
        chk("R5 combined state", card_state, 0);
        pulse_key();
        bus_wr(P_IDX, 8'h02);
        @(negedge clk); key_ok = 1'b1; io_wr = 1'b1; io_addr = P_DAT; io_wdata = 8'h02;
        @(negedge clk); key_ok = 1'b0; io_wr = 1'b0;
        chk("R2 ctrl beats key in sleep", card_state, 0);
        @(negedge clk); key_ok = 1'b1; io_wr = 1'b1; io_addr = P_DAT; io_wdata = 8'h02;
        @(negedge clk); key_ok = 1'b0; io_wr = 1'b0;
        chk("R2 key wins in wait", card_state, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_wait_ignores();
        t_isolation();
        t_csn_and_port();
        t_ctrl_and_wake();
        t_same_cycle();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule